// File: doc/BRIEF.md
# Four-Phase Charge Pump Sequencer

This block drives the switch network of a dual charge pump that builds a positive and a negative supply rail from a single supply. A divider turns the system clock into a slot tick. On each tick the sequencer steps through four switch configurations: charge storage for the negative rail, transfer to the negative rail, charge storage for the positive rail, and transfer to the positive rail. An all-off slot sits between every two configurations, so no two switch sets are ever closed together.

Two comparator flags report whether each rail magnitude has reached its regulation level. The flags go through a synchronizer and are acted on only at slot boundaries. At the end of the positive-transfer phase the sequencer either carries on, or halts with every switch open if both rails are in regulation. While halted, it checks the flags at every tick and starts again at the first phase as soon as either rail sags. Dropping the enable from the power controller opens all switches on the next clock and resets the sequence, so the rails can decay.

Top module: `cpump_seq`

## Requirements
- R1: During and right after reset, `ph_sw` is 0000 and `running` is low.
- R2: Active phases appear on `ph_sw` in the order 0001 (negative charge), 0010 (negative transfer), 0100 (positive charge), 1000 (positive transfer), then 0001 again.
- R3: Each active phase lasts exactly `CLKS_PER_SLOT` clocks. Between two consecutive phases of one run, `ph_sw` is 0000 for exactly `CLKS_PER_SLOT` clocks.
- R4: At most one bit of `ph_sw` is set at any time. A nonzero value is always followed by 0000.
- R5: At the end of the 1000 phase, if both `neg_ok` and `pos_ok` are high the sequencer halts: `ph_sw` goes to 0000, `running` falls, and both stay there. If either flag is low, the sequence continues.
- R6: While running, flag values seen at any point other than the end of the 1000 phase have no effect on the sequence.
- R7: While halted, at each slot tick with either flag low, the sequence restarts at 0001. While both flags stay high, `ph_sw` stays 0000.
- R8: With `pump_en` low, `ph_sw` is 0000 and `running` is low from the next clock onward. When `pump_en` rises with a rail low, 0001 appears exactly `CLKS_PER_SLOT` clocks later.
- R9: `running` is high whenever `ph_sw` is nonzero and during the gaps of a run. It is low while halted or disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pump_en | input | 1 | Enable from the power controller; low opens all switches |
| neg_ok | input | 1 | Negative rail magnitude at or above its regulation level (asynchronous) |
| pos_ok | input | 1 | Positive rail magnitude at or above its regulation level (asynchronous) |
| ph_sw | output | 4 | One-hot switch-set select: bit0 neg charge, bit1 neg transfer, bit2 pos charge, bit3 pos transfer |
| running | output | 1 | High while a pump run is in progress |

## Verification
The assertions check these properties on every clock: the one-hot switch code, the mandatory open slot after each phase, the phase rotation, the slot length, switch changes happening only on a tick or a shutdown, the release on shutdown, and a halt occurring only out of the positive-transfer phase. Other behaviour depends on chosen flag timing and only the bench scenarios can show it. This covers a both-OK pulse that comes and goes mid-run without effect, the halt decision taken right at the end of the last phase, staying idle while both rails are fine, a restart when either rail alone sags, and the exact restart latency after re-enable.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int NPH = 4;

  typedef enum logic [3:0] {
    SL_IDLE, SL_NC, SL_G0, SL_NT, SL_G1, SL_PC, SL_G2, SL_PT, SL_G3
  } slot_t;

  // Next slot on a tick; need = some rail below regulation.
  function automatic slot_t slot_step(input slot_t cur, input logic need);
    case (cur)
      SL_IDLE: slot_step = need ? SL_NC : SL_IDLE;
      SL_NC:   slot_step = SL_G0;
      SL_G0:   slot_step = SL_NT;
      SL_NT:   slot_step = SL_G1;
      SL_G1:   slot_step = SL_PC;
      SL_PC:   slot_step = SL_G2;
      SL_G2:   slot_step = SL_PT;
      SL_PT:   slot_step = need ? SL_G3 : SL_IDLE;
      SL_G3:   slot_step = SL_NC;
      default: slot_step = SL_IDLE;
    endcase
  endfunction

  // Switch-set select for a slot; gaps and idle open everything.
  function automatic logic [NPH-1:0] slot_sw(input slot_t s);
    case (s)
      SL_NC:   slot_sw = NPH'(1) << 0;
      SL_NT:   slot_sw = NPH'(1) << 1;
      SL_PC:   slot_sw = NPH'(1) << 2;
      SL_PT:   slot_sw = NPH'(1) << 3;
      default: slot_sw = '0;
    endcase
  endfunction
endpackage

// File: rtl/cps_tick_div.sv
module cps_tick_div #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!en)     cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/cps_flag_sync.sv
module cps_flag_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  if (STAGES == 0) begin : g_bypass
    assign dout = din;
  end else begin : g_chain
    logic [STAGES-1:0][W-1:0] stg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg <= '0;
      end else begin
        stg[0] <= din;
        for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
    end
    assign dout = stg[STAGES-1];
  end
endmodule

// File: rtl/cps_phase_fsm.sv
module cps_phase_fsm
  import cps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  tick,
  input  logic  neg_ok,
  input  logic  pos_ok,
  output slot_t slot_q,
  output slot_t slot_nxt
);
  logic need;
  assign need = !(neg_ok && pos_ok);

  always_comb begin
    if (!en)       slot_nxt = SL_IDLE;
    else if (tick) slot_nxt = slot_step(slot_q, need);
    else           slot_nxt = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= SL_IDLE;
    else        slot_q <= slot_nxt;
  end
endmodule

// File: rtl/cps_sw_drive.sv
module cps_sw_drive
  import cps_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  slot_t          slot_nxt,
  output logic [NPH-1:0] ph_sw,
  output logic           running
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_sw   <= '0;
      running <= 1'b0;
    end else begin
      ph_sw   <= slot_sw(slot_nxt);
      running <= (slot_nxt != SL_IDLE);
    end
  end
endmodule

// File: rtl/cpump_seq.sv
module cpump_seq
  import cps_pkg::*;
#(
  parameter int CLKS_PER_SLOT = 100,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pump_en,
  input  logic       neg_ok,
  input  logic       pos_ok,
  output logic [3:0] ph_sw,
  output logic       running
);
  logic       slot_tick;
  logic [1:0] ok_sync;
  slot_t      slot_q;
  slot_t      slot_nxt;

  cps_tick_div #(.DIV(CLKS_PER_SLOT)) u_div (
    .clk(clk), .rst_n(rst_n), .en(pump_en), .tick(slot_tick)
  );

  cps_flag_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({pos_ok, neg_ok}), .dout(ok_sync)
  );

  cps_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(pump_en), .tick(slot_tick),
    .neg_ok(ok_sync[0]), .pos_ok(ok_sync[1]),
    .slot_q(slot_q), .slot_nxt(slot_nxt)
  );

  cps_sw_drive u_drv (
    .clk(clk), .rst_n(rst_n), .slot_nxt(slot_nxt),
    .ph_sw(ph_sw), .running(running)
  );
endmodule

// File: rtl/cpump_seq_chk.sv
module cpump_seq_chk #(
  parameter int DIV = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       running,
  input logic       tick,
  input logic [3:0] ph_sw
);
  logic [3:0]  prev_q;
  logic [3:0]  last_nz;
  logic [31:0] run_len;
  logic        chg;

  assign chg = (ph_sw != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      last_nz <= '0;
      run_len <= '0;
    end else begin
      prev_q <= ph_sw;
      if (|ph_sw) last_nz <= ph_sw;
      run_len <= chg ? 32'd1 : run_len + 32'd1;
    end
  end

  AST_ONE_SWITCH_SET: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ph_sw)); // R4
  AST_BREAK_BEFORE_MAKE: assert property (@(posedge clk) disable iff (!rst_n) (chg && |prev_q) |-> (ph_sw == 4'b0000)); // R4
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n) (chg && |ph_sw) |-> (ph_sw == {last_nz[2:0], last_nz[3]} || ph_sw == 4'b0001)); // R2
  AST_SLOT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) (chg && |prev_q && $past(en)) |-> (run_len == DIV)); // R3
  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) chg |-> ($past(tick) || !$past(en))); // R3
  AST_SHUTDOWN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (ph_sw == 4'b0000 && !running)); // R8
  AST_HALT_AFTER_PT: assert property (@(posedge clk) disable iff (!rst_n) ($fell(running) && $past(en)) |-> ($past(ph_sw) == 4'b1000)); // R5
  AST_RUN_COVERS_SW: assert property (@(posedge clk) disable iff (!rst_n) (|ph_sw) |-> running); // R9
  AST_START_AT_NC: assert property (@(posedge clk) disable iff (!rst_n) $rose(running) |-> (ph_sw == 4'b0001)); // R7
endmodule

bind cpump_seq cpump_seq_chk #(.DIV(CLKS_PER_SLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(pump_en), .running(running),
  .tick(slot_tick), .ph_sw(ph_sw)
);

// File: tb/sim_cpump_seq.sv
`timescale 1ns/1ps
module sim_cpump_seq;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pump_en = 1'b0;
  logic       neg_ok = 1'b0;
  logic       pos_ok = 1'b0;
  logic [3:0] ph_sw;
  logic       running;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [3:0] exp_q[$];

  always #2.5 clk = ~clk;

  cpump_seq #(.CLKS_PER_SLOT(DIV), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pump_en(pump_en), .neg_ok(neg_ok),
    .pos_ok(pos_ok), .ph_sw(ph_sw), .running(running)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [3:0] v);
    exp_q.push_back(v);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) cyc++;

  // Monitor: pops expected switch codes as the outputs change.
  logic [3:0] prev_sw = 4'b0000;
  logic       prev_run = 1'b0;
  int         seg_start = 0;
  always @(negedge clk) begin
    if (rst_n && ph_sw !== prev_sw) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected change", int'(ph_sw), int'(prev_sw));
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(ph_sw == e, "R2 phase code", int'(ph_sw), int'(e));
      end
      chk($onehot0(ph_sw), "R4 one-hot", int'(ph_sw), 0);
      if (prev_sw != 4'b0000 && pump_en)
        chk(cyc - seg_start == DIV, "R3 phase length", cyc - seg_start, DIV);
      else if (prev_sw == 4'b0000 && prev_run && pump_en)
        chk(cyc - seg_start == DIV, "R3 gap length", cyc - seg_start, DIV);
      prev_sw   = ph_sw;
      seg_start = cyc;
    end
    prev_run = running;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    neg_ok = 1'b1;
    pos_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk(ph_sw == 4'b0000, "R1 sw in reset", int'(ph_sw), 0);
    chk(running == 1'b0, "R1 running in reset", int'(running), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ph_sw == 4'b0000 && !running, "R1 after reset", int'(ph_sw), 0);

    // R7: enabled with both rails fine -> stays idle
    pump_en = 1'b1;
    repeat (5 * DIV) @(negedge clk);
    chk(ph_sw == 4'b0000, "R7 idle when both ok", int'(ph_sw), 0);
    chk(running == 1'b0, "R7 not running when both ok", int'(running), 0);

    // R7/R2: negative rail sags -> start and rotate
    push(4'b0001); push(4'b0000); push(4'b0010); push(4'b0000);
    push(4'b0100); push(4'b0000); push(4'b1000); push(4'b0000);
    push(4'b0001); push(4'b0000); push(4'b0010);
    neg_ok = 1'b0;
    drain();
    chk(running == 1'b1, "R9 running in phase", int'(running), 1);

    // R6: brief both-ok pulse mid-run has no effect
    neg_ok = 1'b1;
    repeat (2) @(negedge clk);
    neg_ok = 1'b0;
    push(4'b0000); push(4'b0100); push(4'b0000); push(4'b1000);
    push(4'b0000); push(4'b0001);
    drain();
    chk(running == 1'b1, "R6 run continues", int'(running), 1);

    // R5: both ok raised early in the run -> halt after positive transfer
    push(4'b0000); push(4'b0010);
    drain();
    neg_ok = 1'b1;
    push(4'b0000); push(4'b0100); push(4'b0000); push(4'b1000); push(4'b0000);
    drain();
    repeat (6 * DIV) @(negedge clk);
    chk(ph_sw == 4'b0000, "R5 halted sw", int'(ph_sw), 0);
    chk(running == 1'b0, "R5 halted running", int'(running), 0);

    // R7/R5: positive rail alone sags -> restart; both ok inside last phase -> halt
    push(4'b0001); push(4'b0000); push(4'b0010); push(4'b0000);
    push(4'b0100); push(4'b0000); push(4'b1000);
    pos_ok = 1'b0;
    drain();
    pos_ok = 1'b1;
    push(4'b0000);
    drain();
    repeat (6 * DIV) @(negedge clk);
    chk(ph_sw == 4'b0000 && !running, "R5 halt at boundary", int'(ph_sw), 0);

    // R8: shutdown mid-run releases next clock, restart latency
    push(4'b0001); push(4'b0000); push(4'b0010); push(4'b0000); push(4'b0100);
    neg_ok = 1'b0;
    drain();
    push(4'b0000);
    pump_en = 1'b0;
    @(negedge clk);
    chk(ph_sw == 4'b0000, "R8 release sw", int'(ph_sw), 0);
    chk(running == 1'b0, "R8 release running", int'(running), 0);
    repeat (10) @(negedge clk);
    chk(ph_sw == 4'b0000, "R8 stays off while disabled", int'(ph_sw), 0);
    push(4'b0001);
    pump_en = 1'b1;
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    chk(ph_sw == 4'b0000, "R8 not yet restarted", int'(ph_sw), 0);
    @(posedge clk);
    @(negedge clk);
    chk(ph_sw == 4'b0001, "R8 restart at first phase", int'(ph_sw), 1);
    push(4'b0000); push(4'b0010); push(4'b0000); push(4'b0100);
    drain();
    chk(running == 1'b1, "R9 running after restart", int'(running), 1);
    finish_run();
  end
endmodule